// File: doc/BRIEF.md
# Quadrature NCO Down-Mixer with Phase and Amplitude Dither

This block moves a real digital IF sample stream down to complex baseband. Every accepted real sample is multiplied by the cosine and the negated sine of a numerically controlled oscillator. The result is an in-phase and quadrature pair. The oscillator phase is a 32-bit accumulator that advances by a tuning word once for each accepted sample. A separate phase-offset word is added after the accumulator, so several mixers can run with a fixed phase relationship to each other.

Two independent switches reduce spurs. Phase dither adds a pseudo-random value, smaller than one table step, to the phase before the lookup. Amplitude dither adds a small pseudo-random value to each oscillator amplitude before the multiply. Both values come from free-running shift-register generators that restart from fixed nonzero seeds at reset. The sine/cosine table stores one quadrant only. The products are rounded half-up to the output width.

Top module: `nco_quad_mixer`

## Requirements
- R1: After reset the outputs are zero with `out_valid` low, and the accumulator is zero, so the first accepted sample uses phase equal to the offset word.
- R2: `out_valid` is high in exactly the cycle three clock edges after a cycle with `in_valid` high, and it is low otherwise.
- R3: The accumulator adds `tune_word` (modulo 2^32) only on cycles with `in_valid` high. Sample n uses accumulated phase equal to the sum of the tuning words of the earlier accepted samples.
- R4: `phase_offset` is added to the accumulated phase for the lookup only and never enters the accumulator. A changed offset shifts later samples and does not build up.
- R5: With the dithers off, the phase index j is bits [31:22] of (accumulated phase + offset). The oscillator amplitudes are C = round(32765·cos(2π(j+0.5)/1024)) and S = round(32765·sin(2π(j+0.5)/1024)), each within one LSB.
- R6: `out_i` = (x·C + 2^14) >>> 15 and `out_q` = (−x·S + 2^14) >>> 15, with x the signed 16-bit input. Each output is within one LSB.
- R7: With `phase_dither_en` high, an unsigned pseudo-random value in 0..2^20−1 is added to the phase. The index is then j or j+1 (mod 1024), and for a fixed input near a step boundary the outputs change over time.
- R8: With `amp_dither_en` high, a pseudo-random value in −2..+1 is added to C and, separately, to S before the multiply. For a fixed input the outputs change over time.
- R9: Full-scale inputs, including −32768, at any phase give outputs that fit 16 bits without wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 16 | Signed real IF sample |
| tune_word | input | 32 | Phase increment per accepted sample |
| phase_offset | input | 32 | Phase added after the accumulator |
| phase_dither_en | input | 1 | Enables phase dither |
| amp_dither_en | input | 1 | Enables amplitude dither |
| out_valid | output | 1 | Output pair strobe |
| out_i | output | 16 | Signed in-phase result |
| out_q | output | 16 | Signed quadrature result |

## Verification
An accumulator that steps on idle cycles, or that takes in the offset, puts every later sample at a wrong table index. With a nonzero tuning word this shows on the next valid output pair, three cycles later. A wrong quadrant fold or sign shows on the first sample that lands in that quadrant, so a full sweep of all 1024 indices exposes it within one revolution. A dead dither source shows only as outputs that never vary over a few dozen samples with a fixed input, so those runs last long enough to see the dither.

// File: rtl/nco_mix_pkg.sv
package nco_mix_pkg;

  localparam int unsigned DEF_IN_W    = 16;
  localparam int unsigned DEF_AMP_W   = 16;
  localparam int unsigned DEF_OUT_W   = 16;
  localparam int unsigned DEF_PH_W    = 32;
  localparam int unsigned DEF_LUT_W   = 10;
  localparam int unsigned DEF_PDITH_W = 20;
  localparam int unsigned DEF_ADITH_W = 2;

  // First-quadrant sample k of `depth`, taken at the middle of its step,
  // scaled to `peak`; Taylor series evaluated at elaboration time.
  function automatic int quarter_amp(int k, int depth, int peak);
    real ang;
    real x2;
    real term;
    real acc;
    ang  = (real'(k) + 0.5) * 1.5707963267948966 / real'(depth);
    x2   = ang * ang;
    term = ang;
    acc  = ang;
    for (int n = 1; n < 9; n++) begin
      term = -term * x2 / real'((2 * n) * (2 * n + 1));
      acc  = acc + term;
    end
    return $rtoi(acc * real'(peak) + 0.5);
  endfunction

endpackage

// File: rtl/nco_dither_lfsr.sv
module nco_dither_lfsr #(
  parameter int unsigned    W     = 32,
  parameter logic [W-1:0]   TAPS  = 32'h8020_0003,
  parameter logic [W-1:0]   SEED  = 32'h1,
  parameter int unsigned    OUT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] rnd
);

  logic [W-1:0] state_q;
  logic [W-1:0] state_d;

  always_comb begin
    state_d = {1'b0, state_q[W-1:1]};
    if (state_q[0]) begin
      state_d = state_d ^ TAPS;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED;
    end else begin
      state_q <= state_d;
    end
  end

  assign rnd = state_q[OUT_W-1:0];

  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0); // R7

endmodule

// File: rtl/nco_quarter_rom.sv
module nco_quarter_rom #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned AMP_W = 16,
  parameter int          PEAK  = 32765
) (
  input  logic [IDX_W-1:0] addr_a,
  input  logic [IDX_W-1:0] addr_b,
  output logic [AMP_W-1:0] data_a,
  output logic [AMP_W-1:0] data_b
);

  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [AMP_W-1:0] table_w [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_entry
    localparam int VAL = nco_mix_pkg::quarter_amp(k, DEPTH, PEAK);
    assign table_w[k] = AMP_W'(VAL);
  end

  assign data_a = table_w[addr_a];
  assign data_b = table_w[addr_b];

endmodule

// File: rtl/nco_sincos.sv
module nco_sincos #(
  parameter int unsigned LUT_W   = 10,
  parameter int unsigned AMP_W   = 16,
  parameter int          PEAK    = 32765,
  parameter int unsigned ADITH_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [LUT_W-1:0]        phase_idx,
  input  logic                    adith_en,
  input  logic [ADITH_W-1:0]      dith_c,
  input  logic [ADITH_W-1:0]      dith_s,
  output logic signed [AMP_W-1:0] cos_q,
  output logic signed [AMP_W-1:0] nsin_q
);

  localparam int unsigned IDX_W = LUT_W - 2;

  logic [1:0]              quad;
  logic [IDX_W-1:0]        fine;
  logic [IDX_W-1:0]        cos_addr;
  logic [IDX_W-1:0]        sin_addr;
  logic [AMP_W-1:0]        cos_mag;
  logic [AMP_W-1:0]        sin_mag;
  logic signed [AMP_W-1:0] cos_sgn;
  logic signed [AMP_W-1:0] sin_sgn;
  logic signed [AMP_W-1:0] dc_ext;
  logic signed [AMP_W-1:0] ds_ext;
  logic signed [AMP_W-1:0] cos_d;
  logic signed [AMP_W-1:0] nsin_d;

  assign quad = phase_idx[LUT_W-1 -: 2];
  assign fine = phase_idx[IDX_W-1:0];

  always_comb begin
    sin_addr = quad[0] ? ~fine : fine;
    cos_addr = quad[0] ? fine  : ~fine;
  end

  nco_quarter_rom #(
    .IDX_W (IDX_W),
    .AMP_W (AMP_W),
    .PEAK  (PEAK)
  ) u_rom (
    .addr_a (cos_addr),
    .addr_b (sin_addr),
    .data_a (cos_mag),
    .data_b (sin_mag)
  );

  always_comb begin
    cos_sgn = (quad[0] ^ quad[1]) ? -$signed(cos_mag) : $signed(cos_mag);
    sin_sgn = quad[1] ? -$signed(sin_mag) : $signed(sin_mag);
    if (adith_en) begin
      dc_ext = {{(AMP_W-ADITH_W){dith_c[ADITH_W-1]}}, dith_c};
      ds_ext = {{(AMP_W-ADITH_W){dith_s[ADITH_W-1]}}, dith_s};
    end else begin
      dc_ext = '0;
      ds_ext = '0;
    end
    cos_d  = cos_sgn + dc_ext;
    nsin_d = -(sin_sgn + ds_ext);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cos_q  <= '0;
      nsin_q <= '0;
    end else if (en) begin
      cos_q  <= cos_d;
      nsin_q <= nsin_d;
    end
  end

  function automatic int mag(logic signed [AMP_W-1:0] v);
    return (v < 0) ? -int'(v) : int'(v);
  endfunction

  AST_AMP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mag(cos_q) <= PEAK + 2) && (mag(nsin_q) <= PEAK + 2)); // R8

  AST_QUAD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && !$past(adith_en)) |-> (mag(cos_q) + mag(nsin_q) >= PEAK - 2)); // R5

endmodule

// File: rtl/nco_quad_mixer.sv
module nco_quad_mixer #(
  parameter int unsigned IN_W    = nco_mix_pkg::DEF_IN_W,
  parameter int unsigned AMP_W   = nco_mix_pkg::DEF_AMP_W,
  parameter int unsigned OUT_W   = nco_mix_pkg::DEF_OUT_W,
  parameter int unsigned PH_W    = nco_mix_pkg::DEF_PH_W,
  parameter int unsigned LUT_W   = nco_mix_pkg::DEF_LUT_W,
  parameter int unsigned PDITH_W = nco_mix_pkg::DEF_PDITH_W,
  parameter int unsigned ADITH_W = nco_mix_pkg::DEF_ADITH_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_sample,
  input  logic [PH_W-1:0]         tune_word,
  input  logic [PH_W-1:0]         phase_offset,
  input  logic                    phase_dither_en,
  input  logic                    amp_dither_en,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_i,
  output logic signed [OUT_W-1:0] out_q
);

  localparam int          PEAK   = (1 << (AMP_W - 1)) - 1 - (1 << (ADITH_W - 1));
  localparam int unsigned PROD_W = IN_W + AMP_W;
  localparam int unsigned SUM_W  = PROD_W + 1;
  localparam int unsigned SHIFT  = PROD_W - 1 - OUT_W;
  localparam logic signed [SUM_W-1:0] HALF = SUM_W'(1) << (SHIFT - 1);

  // reset release synchroniser
  logic rst_q1;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_q1     <= 1'b1;
      rst_sync_n <= rst_q1;
    end
  end

  // dither sources
  logic [PDITH_W-1:0]   pd_rnd;
  logic [2*ADITH_W-1:0] ad_rnd;

  nco_dither_lfsr #(
    .W     (32),
    .TAPS  (32'h8020_0003),
    .SEED  (32'h5A5A_1F3D),
    .OUT_W (PDITH_W)
  ) u_pd_lfsr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .rnd   (pd_rnd)
  );

  nco_dither_lfsr #(
    .W     (16),
    .TAPS  (16'hB400),
    .SEED  (16'hACE1),
    .OUT_W (2 * ADITH_W)
  ) u_ad_lfsr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .rnd   (ad_rnd)
  );

  // stage 0: accumulator and phase sum
  logic [PH_W-1:0] acc_q;
  logic [PH_W-1:0] acc_d;
  logic [PH_W-1:0] ph_dith;
  logic [PH_W-1:0] ph_sum;
  logic            unused_ph_lo;

  always_comb begin
    acc_d   = in_valid ? acc_q + tune_word : acc_q;
    ph_dith = phase_dither_en ? {{(PH_W-PDITH_W){1'b0}}, pd_rnd} : '0;
    ph_sum  = acc_q + phase_offset + ph_dith;
  end

  assign unused_ph_lo = ^ph_sum[PH_W-LUT_W-1:0];

  // stage 1 registers
  logic                   s1_valid;
  logic signed [IN_W-1:0] s1_x;
  logic [LUT_W-1:0]       s1_idx;
  logic                   s1_ad_en;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_q    <= '0;
      s1_valid <= 1'b0;
      s1_x     <= '0;
      s1_idx   <= '0;
      s1_ad_en <= 1'b0;
    end else begin
      acc_q    <= acc_d;
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_x     <= in_sample;
        s1_idx   <= ph_sum[PH_W-1 -: LUT_W];
        s1_ad_en <= amp_dither_en;
      end
    end
  end

  // stage 2: oscillator lookup
  logic                    s2_valid;
  logic signed [IN_W-1:0]  s2_x;
  logic signed [AMP_W-1:0] cos_q;
  logic signed [AMP_W-1:0] nsin_q;

  nco_sincos #(
    .LUT_W   (LUT_W),
    .AMP_W   (AMP_W),
    .PEAK    (PEAK),
    .ADITH_W (ADITH_W)
  ) u_sincos (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .en        (s1_valid),
    .phase_idx (s1_idx),
    .adith_en  (s1_ad_en),
    .dith_c    (ad_rnd[ADITH_W-1:0]),
    .dith_s    (ad_rnd[2*ADITH_W-1:ADITH_W]),
    .cos_q     (cos_q),
    .nsin_q    (nsin_q)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s2_valid <= 1'b0;
      s2_x     <= '0;
    end else begin
      s2_valid <= s1_valid;
      if (s1_valid) begin
        s2_x <= s1_x;
      end
    end
  end

  // stage 3: multiply and round half-up
  logic signed [PROD_W-1:0] prod_i;
  logic signed [PROD_W-1:0] prod_q;
  logic signed [SUM_W-1:0]  sh_i;
  logic signed [SUM_W-1:0]  sh_q;

  always_comb begin
    prod_i = s2_x * cos_q;
    prod_q = s2_x * nsin_q;
    sh_i   = ($signed({prod_i[PROD_W-1], prod_i}) + HALF) >>> SHIFT;
    sh_q   = ($signed({prod_q[PROD_W-1], prod_q}) + HALF) >>> SHIFT;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= s2_valid;
      if (s2_valid) begin
        out_i <= sh_i[OUT_W-1:0];
        out_q <= sh_q[OUT_W-1:0];
      end
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> $past(in_valid, 3)); // R2

  AST_NO_OVERFLOW_I: assert property (@(posedge clk) disable iff (!rst_sync_n)
    s2_valid |-> ((sh_i[SUM_W-1:OUT_W-1] == '0) || (sh_i[SUM_W-1:OUT_W-1] == '1))); // R9

  AST_NO_OVERFLOW_Q: assert property (@(posedge clk) disable iff (!rst_sync_n)
    s2_valid |-> ((sh_q[SUM_W-1:OUT_W-1] == '0) || (sh_q[SUM_W-1:OUT_W-1] == '1))); // R9

endmodule

// File: tb/nco_quad_mixer_tb.sv
module nco_quad_mixer_tb;

  localparam real PI = 3.14159265358979323846;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               in_valid;
  logic signed [15:0] in_sample;
  logic [31:0]        tune_word;
  logic [31:0]        phase_offset;
  logic               phase_dither_en;
  logic               amp_dither_en;
  logic               out_valid;
  logic signed [15:0] out_i;
  logic signed [15:0] out_q;

  always #2.5 clk = ~clk;

  nco_quad_mixer u_dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .in_valid        (in_valid),
    .in_sample       (in_sample),
    .tune_word       (tune_word),
    .phase_offset    (phase_offset),
    .phase_dither_en (phase_dither_en),
    .amp_dither_en   (amp_dither_en),
    .out_valid       (out_valid),
    .out_i           (out_i),
    .out_q           (out_q)
  );

  int    n_checks = 0;
  int    n_fails  = 0;
  bit    done     = 1'b0;
  string tag      = "R1";

  logic [31:0] cfg_tune = '0;
  logic [31:0] cfg_off  = '0;
  bit          cfg_pd   = 1'b0;
  bit          cfg_ad   = 1'b0;
  logic [31:0] acc_m    = '0;

  bit  pv  [3];
  int  px  [3];
  int  pj  [3];
  bit  ppd [3];
  bit  pad [3];

  bit collect = 1'b0;
  int min_i, max_i, min_q, max_q;

  function automatic int rnd_real(real r);
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
  endfunction

  function automatic int cos_amp(int j);
    return rnd_real(32765.0 * $cos(2.0 * PI * (real'(j) + 0.5) / 1024.0));
  endfunction

  function automatic int sin_amp(int j);
    return rnd_real(32765.0 * $sin(2.0 * PI * (real'(j) + 0.5) / 1024.0));
  endfunction

  function automatic longint mix_round(longint x, longint a);
    return (x * a + 64'sd16384) >>> 15;
  endfunction

  function automatic bit close1(longint act, longint exp);
    return (act - exp <= 1) && (exp - act <= 1);
  endfunction

  task automatic check(bit ok, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_data(int x, int j, bit pd, bit ad);
    bit     ok_i = 1'b0;
    bit     ok_q = 1'b0;
    longint ei0, eq0;
    ei0 = mix_round(x, cos_amp(j));
    eq0 = mix_round(x, -sin_amp(j));
    for (int dj = 0; dj <= (pd ? 1 : 0); dj++) begin
      for (int d = (ad ? -2 : 0); d <= (ad ? 1 : 0); d++) begin
        int jj = (j + dj) % 1024;
        if (close1(out_i, mix_round(x, cos_amp(jj) + d)))    ok_i = 1'b1;
        if (close1(out_q, mix_round(x, -(sin_amp(jj) + d)))) ok_q = 1'b1;
      end
    end
    check(ok_i, "out_i", out_i, ei0);
    check(ok_q, "out_q", out_q, eq0);
    if (collect) begin
      if (out_i < min_i) min_i = out_i;
      if (out_i > max_i) max_i = out_i;
      if (out_q < min_q) min_q = out_q;
      if (out_q > max_q) max_q = out_q;
    end
  endtask

  // One negedge: check what entered three negedges ago, then drive.
  task automatic step(bit v, int x);
    logic [31:0] ph;
    @(negedge clk);
    n_checks++;
    if (out_valid !== pv[2]) begin
      n_fails++;
      $display("FAIL R2: out_valid actual=%0d expected=%0d", out_valid, pv[2]);
    end
    if (pv[2]) check_data(px[2], pj[2], ppd[2], pad[2]);
    for (int k = 2; k > 0; k--) begin
      pv[k] = pv[k-1]; px[k] = px[k-1]; pj[k] = pj[k-1];
      ppd[k] = ppd[k-1]; pad[k] = pad[k-1];
    end
    ph     = acc_m + cfg_off;
    pv[0]  = v;
    px[0]  = x;
    pj[0]  = int'(ph[31:22]);
    ppd[0] = cfg_pd;
    pad[0] = cfg_ad;
    if (v) acc_m = acc_m + cfg_tune;
    in_valid        = v;
    in_sample       = 16'(x);
    tune_word       = cfg_tune;
    phase_offset    = cfg_off;
    phase_dither_en = cfg_pd;
    amp_dither_en   = cfg_ad;
  endtask

  task automatic drain();
    for (int k = 0; k < 4; k++) step(1'b0, 0);
  endtask

  function automatic int rand_x();
    return int'($urandom_range(65535)) - 32768;
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 3; k++) begin
      pv[k] = 0; px[k] = 0; pj[k] = 0; ppd[k] = 0; pad[k] = 0;
    end
    rst_n = 1'b0; in_valid = 1'b0; in_sample = '0; tune_word = '0;
    phase_offset = '0; phase_dither_en = 1'b0; amp_dither_en = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state and zero accumulator on the first sample
    tag = "R1";
    check(out_valid == 1'b0, "reset out_valid", out_valid, 0);
    check(out_i == 0, "reset out_i", out_i, 0);
    check(out_q == 0, "reset out_q", out_q, 0);
    cfg_tune = 32'h1234_5678; cfg_off = 32'h4000_0000;
    step(1'b1, 20000);
    step(1'b1, -12345);
    drain();

    // R5: full table sweep, one index per sample
    tag = "R5";
    cfg_tune = 32'h0040_0000; cfg_off = 32'h0000_0000;
    for (int k = 0; k < 1024; k++) step(1'b1, 32767);
    drain();

    // R3: random tuning words and random gaps
    tag = "R3";
    for (int k = 0; k < 400; k++) begin
      if (k % 50 == 0) cfg_tune = $urandom();
      step($urandom_range(99) < 60, rand_x());
    end
    drain();

    // R4: offset changes mid-stream, accumulator unaffected
    tag = "R4";
    cfg_tune = 32'h0123_4567;
    for (int k = 0; k < 120; k++) begin
      if (k % 20 == 0) cfg_off = $urandom();
      step(1'b1, rand_x());
    end
    drain();

    // R6: rounding with small and mid-range magnitudes
    tag = "R6";
    cfg_tune = 32'h0B00_0000; cfg_off = 32'h0010_0000;
    for (int k = 0; k < 60; k++) begin
      int xs[8] = '{1, -1, 3, -3, 7, -7, 16384, -16385};
      step(1'b1, xs[k % 8]);
    end
    drain();

    // R9: full scale at quadrant edges
    tag = "R9";
    cfg_tune = 32'h0;
    for (int q = 0; q < 8; q++) begin
      int js[8] = '{0, 255, 256, 511, 512, 767, 768, 1023};
      cfg_off = 32'(js[q]) << 22;
      step(1'b1, -32768);
      step(1'b1, 32767);
    end
    drain();

    // R7: phase dither bound and visible variation near a step boundary
    tag = "R7";
    cfg_pd = 1'b1;
    cfg_tune = 32'h0777_7777;
    for (int k = 0; k < 100; k++) step(1'b1, rand_x());
    drain();
    cfg_tune = '0; cfg_off = 32'h0040_0000 - 32'h0008_0000;
    min_i = 99999; max_i = -99999; min_q = 99999; max_q = -99999;
    collect = 1'b1;
    for (int k = 0; k < 64; k++) step(1'b1, 32767);
    drain();
    collect = 1'b0;
    check(max_q != min_q, "out_q spread with phase dither", max_q - min_q, 1);
    cfg_pd = 1'b0;

    // R8: amplitude dither bound and visible variation
    tag = "R8";
    cfg_ad = 1'b1;
    cfg_tune = 32'h0313_5791;
    for (int k = 0; k < 100; k++) step(1'b1, rand_x());
    drain();
    cfg_tune = '0; cfg_off = 32'h2020_0000;
    min_i = 99999; max_i = -99999; min_q = 99999; max_q = -99999;
    collect = 1'b1;
    for (int k = 0; k < 64; k++) step(1'b1, 32767);
    drain();
    collect = 1'b0;
    check(max_i != min_i, "out_i spread with amplitude dither", max_i - min_i, 1);
    check(max_q != min_q, "out_q spread with amplitude dither", max_q - min_q, 1);
    cfg_ad = 1'b0;

    // R2: sparse strobes, both dithers on
    tag = "R2";
    cfg_pd = 1'b1; cfg_ad = 1'b1; cfg_tune = 32'h0F0F_0F0F;
    for (int k = 0; k < 200; k++) step($urandom_range(99) < 25, rand_x());
    drain();

    done = 1'b1;
    finish_run();
  end

endmodule